// File: doc/BRIEF.md
# Command Ring Fetch Engine

This block drains a circular queue of 32-bit commands that software keeps in system memory. It places each command into the command slot of one outgoing link frame. Software sets the ring's base address and size, advances a write pointer, and sets a run bit. The engine compares its own read pointer with the write pointer. While they differ, it reads the next entry over a single-outstanding memory read handshake. It holds the fetched word until the next frame-start strobe and then presents it on the slot outputs for that whole frame.

Both pointers count whole commands. The write pointer names the last valid entry, so the entry fetched next always sits one index past the read pointer. The read pointer advances by one for each response received and wraps at the end of the selected ring. Command contents are opaque: an all-zero word is forwarded like any other value.

The sequencer has four states:
- ST_IDLE: no request.
- ST_REQ: request raised.
- ST_WAIT: awaiting read data.
- ST_HOLD: one fetched command buffered.

Its transitions are:
- ST_IDLE to ST_REQ when run is set and work is pending.
- ST_REQ to ST_WAIT when the request is accepted.
- ST_WAIT to ST_HOLD when read data returns.
- ST_HOLD to ST_IDLE on a frame-start strobe.

Top module: `cmd_ring_fetcher`

## Requirements
- R1: After reset, slot_valid and slot_cmd are 0, no memory request is raised, and the control, write-pointer and read-pointer registers read 0.
- R2: Register map on reg_addr:
  - 0 is control. Bit 0 is run, and it reads back. Writing 1 to bit 1 clears the read pointer; that bit reads 0.
  - 1 is size, bits [1:0]: 0 selects 2 entries, 1 selects 16, and 2 or 3 select 256.
  - 2 is the low half of the base address.
  - 3 is the high half of the base address.
  - 4 is the write pointer, bits [7:0].
  - 5 is the read pointer. It is read-only and reads back as a masked index.
- R3: The fetch address is base + 4 × ((read pointer + 1) mod ring size). With both pointers at 0, the first fetch reads byte offset 4.
- R4: While run is set and the pointers differ, entries are fetched one after another. The read pointer advances by one per returned command until it equals the write pointer. No request is then raised.
- R5: The read pointer wraps to 0 after the last entry of the selected size. Only 1, 4 or 8 low pointer bits are significant, for 2, 16 or 256 entries.
- R6: The low 7 bits of the base address are forced to 0 on write, both in readback and in fetch addresses.
- R7: At a frame-start strobe with a command buffered, slot_cmd takes the unchanged 32-bit word and slot_valid goes to 1. Both hold until the next strobe, so each frame carries at most one command.
- R8: At a frame-start strobe with no command buffered, slot_cmd is 0 and slot_valid is 0 for that frame.
- R9: A write-pointer advance during a drain extends it, and the newly added entries are also sent.
- R10: An all-zero command is delivered with slot_valid 1, exactly like any other command.
- R11: With run cleared, no new request is raised. A request already accepted still completes and its command is delivered. The pointers then stay unchanged.
- R12: The read-pointer clear bit sets the read pointer to 0. Writing 0 to the write pointer clears it.
- R13: While mem_req_valid is high and mem_req_ready is low, the request and its address stay stable. At most one read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory read request accepted |
| mem_req_addr | output | 64 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| frame_start | input | 1 | Start of a link frame |
| slot_cmd | output | 32 | Command for the current frame |
| slot_valid | output | 1 | Current frame carries a command |

## Verification
- **Address errors:** the bench's memory returns a word derived from the requested address. A wrong index, wrap, mask or alignment therefore shows up in slot_cmd at the very next frame.
- **Pointer errors:** a read pointer that skips, stalls or overruns changes both the order of the commands and the read-pointer register. That register is compared before every frame.
- **Sequencing errors:** a stuck or premature sequencer state shows up within one frame, as a missing command, a slot_valid of 1 where 0 is expected, or a request raised while stopped.

// File: rtl/cmd_ring_pkg.sv
package cmd_ring_pkg;
    localparam int CMD_W       = 32;
    localparam int REG_W       = 32;
    localparam int MAX_ENTRIES = 256;
    localparam int PTR_W       = $clog2(MAX_ENTRIES);
    localparam int SMALL_LOG   = 1;
    localparam int MID_LOG     = 4;
    localparam int ENTRY_SHIFT = $clog2(CMD_W / 8);
    localparam int ALIGN_BITS  = 7;
    localparam int REG_AW      = 3;

    typedef enum logic [REG_AW-1:0] {
        RA_CTRL    = 3'd0,
        RA_SIZE    = 3'd1,
        RA_BASE_LO = 3'd2,
        RA_BASE_HI = 3'd3,
        RA_WPTR    = 3'd4,
        RA_RPTR    = 3'd5
    } reg_addr_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_HOLD
    } fetch_state_e;

    function automatic logic [PTR_W-1:0] idx_mask(input logic [1:0] code);
        case (code)
            2'd0:    return PTR_W'((1 << SMALL_LOG) - 1);
            2'd1:    return PTR_W'((1 << MID_LOG) - 1);
            default: return '1;
        endcase
    endfunction
endpackage

// File: rtl/cmd_ring_regs.sv
module cmd_ring_regs
    import cmd_ring_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic              rp_inc,
    output logic              run,
    output logic              pending,
    output logic [PTR_W-1:0]  next_idx,
    output logic [ADDR_W-1:0] base
);
    localparam int HI_W = ADDR_W - REG_W;

    logic              run_q;
    logic [1:0]        size_q;
    logic [REG_W-1:0]  base_lo_q;
    logic [HI_W-1:0]   base_hi_q;
    logic [PTR_W-1:0]  wp_q, rp_q;
    logic [PTR_W-1:0]  mask, rp_idx, wp_idx;
    logic              wr_ctrl, rp_clr;

    assign wr_ctrl = wr_en && (reg_addr == RA_CTRL);
    assign rp_clr  = wr_ctrl && wdata[1];

    always_comb begin
        mask     = idx_mask(size_q);
        rp_idx   = rp_q & mask;
        wp_idx   = wp_q & mask;
        next_idx = (rp_idx + PTR_W'(1)) & mask;
        pending  = (rp_idx != wp_idx);
        run      = run_q;
        base     = {base_hi_q, base_lo_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q     <= 1'b0;
            size_q    <= 2'd0;
            base_lo_q <= '0;
            base_hi_q <= '0;
            wp_q      <= '0;
        end else if (wr_en) begin
            case (reg_addr)
                RA_CTRL:    run_q     <= wdata[0];
                RA_SIZE:    size_q    <= wdata[1:0];
                RA_BASE_LO: base_lo_q <= {wdata[REG_W-1:ALIGN_BITS], ALIGN_BITS'(0)};
                RA_BASE_HI: base_hi_q <= wdata[HI_W-1:0];
                RA_WPTR:    wp_q      <= wdata[PTR_W-1:0];
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rp_q <= '0;
        else if (rp_clr) rp_q <= '0;
        else if (rp_inc) rp_q <= next_idx;
    end

    always_comb begin
        case (reg_addr)
            RA_CTRL:    rdata = REG_W'(run_q);
            RA_SIZE:    rdata = REG_W'(size_q);
            RA_BASE_LO: rdata = base_lo_q;
            RA_BASE_HI: rdata = REG_W'(base_hi_q);
            RA_WPTR:    rdata = REG_W'(wp_q);
            RA_RPTR:    rdata = REG_W'(rp_idx);
            default:    rdata = '0;
        endcase
    end

    // R4: the read pointer moves only on a returned command or a clear
    p_rp_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rp_clr && !rp_inc) |=> (rp_q == $past(rp_q)));

    // R12: a clear request zeroes the read pointer
    p_rp_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rp_clr |=> (rp_q == '0));
endmodule

// File: rtl/cmd_ring_fsm.sv
module cmd_ring_fsm
    import cmd_ring_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              pending,
    input  logic [ADDR_W-1:0] base,
    input  logic [PTR_W-1:0]  next_idx,
    input  logic              frame_start,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [CMD_W-1:0]  mem_rsp_data,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic              rp_inc,
    output logic              hold_valid,
    output logic [CMD_W-1:0]  hold_data
);
    fetch_state_e      state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [CMD_W-1:0]  data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (run && pending) state_d = ST_REQ;
            ST_REQ:  if (mem_req_ready)  state_d = ST_WAIT;
            ST_WAIT: if (mem_rsp_valid)  state_d = ST_HOLD;
            ST_HOLD: if (frame_start)    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else begin
            if (state_q == ST_IDLE && state_d == ST_REQ)
                addr_q <= base + (ADDR_W'(next_idx) << ENTRY_SHIFT);
            if (state_q == ST_WAIT && mem_rsp_valid)
                data_q <= mem_rsp_data;
        end
    end

    always_comb begin
        mem_req_valid = 1'b0;
        rp_inc        = 1'b0;
        hold_valid    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_REQ:  mem_req_valid = 1'b1;
            ST_WAIT: rp_inc        = mem_rsp_valid;
            ST_HOLD: hold_valid    = 1'b1;
        endcase
        mem_req_addr = addr_q;
        hold_data    = data_q;
    end

    // R13: a stalled request keeps its address
    p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R4: drained and idle means no request next cycle
    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !pending) |=> !mem_req_valid);

    // R11: stopped and idle raises nothing
    p_stop_no_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !run) |=> !mem_req_valid);

    // R7: a returned command is buffered for the next frame
    p_fetch_buffered_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rp_inc |=> hold_valid);
endmodule

// File: rtl/cmd_ring_slot.sv
module cmd_ring_slot
    import cmd_ring_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             hold_valid,
    input  logic [CMD_W-1:0] hold_data,
    output logic [CMD_W-1:0] slot_cmd,
    output logic             slot_valid
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_cmd   <= '0;
            slot_valid <= 1'b0;
        end else if (frame_start) begin
            slot_cmd   <= hold_valid ? hold_data : '0;
            slot_valid <= hold_valid;
        end
    end

    // R7: the slot only changes at a frame boundary
    p_slot_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(slot_cmd) && $stable(slot_valid)));

    // R8: an empty frame carries a null, not-valid slot
    p_empty_null_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !hold_valid) |=> (!slot_valid && slot_cmd == '0));
endmodule

// File: rtl/cmd_ring_fetcher.sv
module cmd_ring_fetcher
    import cmd_ring_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [CMD_W-1:0]  mem_rsp_data,
    input  logic              frame_start,
    output logic [CMD_W-1:0]  slot_cmd,
    output logic              slot_valid
);
    logic              run, pending, rp_inc, hold_valid;
    logic [PTR_W-1:0]  next_idx;
    logic [ADDR_W-1:0] base;
    logic [CMD_W-1:0]  hold_data;

    cmd_ring_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .reg_addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .rp_inc(rp_inc), .run(run),
        .pending(pending), .next_idx(next_idx), .base(base)
    );

    cmd_ring_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .run(run), .pending(pending), .base(base),
        .next_idx(next_idx), .frame_start(frame_start),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .mem_req_valid(mem_req_valid),
        .mem_req_addr(mem_req_addr), .rp_inc(rp_inc),
        .hold_valid(hold_valid), .hold_data(hold_data)
    );

    cmd_ring_slot u_slot (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .hold_valid(hold_valid), .hold_data(hold_data),
        .slot_cmd(slot_cmd), .slot_valid(slot_valid)
    );

    // R6: fetch addresses stay aligned to whole entries
    p_addr_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[ENTRY_SHIFT-1:0] == '0));
endmodule

// File: tb/sim_cmd_ring_fetcher.sv
`timescale 1ns/1ps
module sim_cmd_ring_fetcher;
    localparam int GAP = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        frame_start = 1'b0;
    logic [31:0] slot_cmd;
    logic        slot_valid;

    always #5 clk = ~clk;

    cmd_ring_fetcher u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .frame_start(frame_start),
        .slot_cmd(slot_cmd), .slot_valid(slot_valid)
    );

    int    n_chk = 0, n_fail = 0;
    bit    chk_on = 0, done = 0;
    string cur_tag = "R1";

    // behavioural reference state
    logic [63:0] null_addr = '1;
    logic [63:0] m_base = '0;
    int          m_rp = 0, m_wp = 0, m_mask = 1;
    bit          m_run = 0, m_bv = 0, m_sv = 0;
    logic [31:0] m_buf = '0, m_slot = '0;

    function automatic logic [31:0] memfn(input logic [63:0] a);
        if (a == null_addr) return 32'h0;
        return a[31:0] ^ {a[47:32], 16'h0} ^ 32'h3C00_0000;
    endfunction

    // bench memory: ready pattern, latency, optional hold of the reply
    bit          hold = 0, pend = 0, prev_stall = 0;
    int          cnt = 0, cyc = 0;
    logic [63:0] paddr = '0, prev_addr = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (prev_stall) begin
                n_chk++;
                if (!(mem_req_valid && mem_req_addr == prev_addr)) begin
                    n_fail++;
                    $display("FAIL R13 stalled request valid=%b addr=%h expected valid=1 addr=%h",
                             mem_req_valid, mem_req_addr, prev_addr);
                end
            end
            mem_rsp_valid = 1'b0;
            if (pend && cnt == 0 && !hold) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = memfn(paddr);
                pend = 0;
            end else if (pend && cnt > 0) begin
                cnt--;
            end
            mem_req_ready = ((cyc % 3) != 1);
            prev_stall = mem_req_valid && !mem_req_ready;
            prev_addr  = mem_req_addr;
            if (mem_req_valid && mem_req_ready) begin
                pend = 1; paddr = mem_req_addr; cnt = 2;
            end
        end
    end

    // slot comparison on every clock
    always @(negedge clk) begin
        if (chk_on && !done) begin
            n_chk++;
            if (slot_cmd !== m_slot || slot_valid !== m_sv) begin
                n_fail++;
                $display("FAIL %s slot cmd=%h valid=%b expected cmd=%h valid=%b",
                         cur_tag, slot_cmd, slot_valid, m_slot, m_sv);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        n_chk++;
        if (reg_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s reg %0d read %h expected %h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic set_run(input bit r);
        wr(3'd0, {31'd0, r}); m_run = r;
    endtask

    task automatic set_wp(input int v);
        wr(3'd4, 32'(v)); m_wp = v;
    endtask

    task automatic set_size(input int code);
        wr(3'd1, 32'(code));
        m_mask = (code == 0) ? 1 : (code == 1) ? 15 : 255;
        m_rp = m_rp & m_mask;
    endtask

    task automatic model_take();
        int nxt;
        nxt   = (m_rp + 1) & m_mask;
        m_buf = memfn(m_base + 64'(nxt * 4));
        m_rp  = nxt;
        m_bv  = 1;
    endtask

    task automatic frame();
        repeat (GAP) @(negedge clk);
        if (!m_bv && m_run && m_rp != (m_wp & m_mask)) model_take();
        rd_chk(3'd5, 32'(m_rp), {cur_tag, " read pointer"});
        @(negedge clk);
        frame_start = 1'b1;
        @(posedge clk);
        m_slot = m_bv ? m_buf : 32'h0;
        m_sv   = m_bv;
        m_bv   = 0;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_on = 1;
        // R1: reset state
        cur_tag = "R1";
        rd_chk(3'd0, 32'h0, "R1 control");
        rd_chk(3'd4, 32'h0, "R1 write pointer");
        rd_chk(3'd5, 32'h0, "R1 read pointer");
        n_chk++;
        if (mem_req_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 mem_req_valid=%b expected 0", mem_req_valid);
        end

        // R2, R6: configuration and alignment
        cur_tag = "R2";
        set_size(1);
        wr(3'd2, 32'h0001_207F);
        wr(3'd3, 32'h0000_0012);
        m_base = {32'h12, 32'h0001_2000};
        rd_chk(3'd1, 32'h1, "R2 size");
        rd_chk(3'd2, 32'h0001_2000, "R6 base low aligned");
        rd_chk(3'd3, 32'h12, "R2 base high");
        set_run(1);
        rd_chk(3'd0, 32'h1, "R2 run readback");
        cur_tag = "R8";
        frame();

        // R3, R4, R7: first drain starts at offset 4
        cur_tag = "R3";
        set_wp(3);
        frame();
        cur_tag = "R4";
        frame(); frame();
        cur_tag = "R8";
        frame();

        // R9: extend during a drain
        cur_tag = "R9";
        set_wp(5);
        frame();
        set_wp(8);
        for (int i = 0; i < 4; i++) frame();
        frame();

        // R10: null command
        cur_tag = "R10";
        null_addr = m_base + 64'(9 * 4);
        set_wp(9);
        frame();
        null_addr = '1;

        // R5: wrap in a 16-entry ring, upper pointer bits ignored
        cur_tag = "R5";
        set_wp(32'hF1);
        for (int i = 0; i < 9; i++) frame();
        rd_chk(3'd5, 32'h1, "R5 wrapped read pointer");

        // R5: 2-entry ring
        set_size(0);
        set_wp(0);
        frame();
        set_wp(1);
        frame();
        frame();

        // R11: stopped, then a fetch in flight when run clears
        cur_tag = "R11";
        set_run(0);
        set_size(1);
        set_wp(4);
        frame();
        hold = 1;
        set_run(1);
        repeat (8) @(negedge clk);
        set_run(0);
        model_take();
        hold = 0;
        frame();
        frame();
        frame();

        // R12: pointer clears
        cur_tag = "R12";
        wr(3'd0, 32'h2);
        m_run = 0; m_rp = 0;
        set_wp(0);
        rd_chk(3'd4, 32'h0, "R12 write pointer");
        rd_chk(3'd5, 32'h0, "R12 read pointer");
        set_run(1);
        frame();
        set_wp(2);
        frame(); frame(); frame();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule